// File: doc/BRIEF.md
# Polyphase scaler phase stepper

This block drives one scaling direction of a display scaler. For every output pixel of a line it emits, for a luma channel and a chroma channel together, the integer source sample index and a 5-bit filter phase. The phase selects one of 32 coefficient sets. The multiply-accumulate filter and the memory fetch sit downstream and are not part of the block.

Software writes the luma input size, the shared output size, a chroma subsampling shift and two initial phases into staging registers. A commit makes these values active. The commit also starts two sequential dividers, which produce the 16.16 step of each channel. A line-start request then scans one line. The block also holds a 32-phase coefficient store. Software loads that store through the same register port while an access bit is set. The filter reads it by phase, and each entry carries a fixed number of words per phase.

Register addresses on the port are: 0 luma input size, 1 output size, 2 mode, 3 luma initial phase, 4 chroma initial phase, 5 control. Coefficient words sit at 0x40 + phase*WPP + word.

Top module: `scl_phase_stepper`

## Requirements
- R1: Writes to addresses 0 to 4 only stage values. They become active on a control write with bit 0 (commit) set, and a commit is ignored while a step is being computed or a line is being scanned.
- R2: Each channel's step equals floor((input_size * 65536) / output_size), an unsigned 16.16 increment.
- R3: The chroma input size is the luma input size divided by 2^shift, rounded up, where shift is mode bits [1:0]. Both channels use the one output size.
- R4: A control write with bit 1 (line start) and bit 0 clear emits exactly output_size pixels, one per clock, with `line_done` high on the last one only. It is ignored during step computation, during a scan, or while the active output size is zero.
- R5: At each line start a channel's accumulator reloads its initial phase and then adds its step once per pixel. The index is the accumulator's integer part and the phase is accumulator bits [15:11].
- R6: Initial phases are 20-bit two's complement values with 16 fraction bits. The chroma channel uses its own initial phase only when mode bit 4 (multi-plane source) is set; otherwise it uses the luma initial phase.
- R7: An emitted index is clamped to the range 0 to input_size-1 of its channel.
- R8: Coefficient writes take effect only while control bit 2 (access hold) is set; other coefficient writes are dropped.
- R9: Reads return the active coefficient set. The active set takes the staged set on the cycle after the hold bit is released, so reads made during a hold return the previous set.
- R10: The read data for `coef_rd_phase` appears one cycle later, with word w of the phase at bits [w*COEF_W +: COEF_W].
- R11: After reset no pixel is valid, all active sizes are zero (so a line start is ignored), and every coefficient reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register or coefficient address |
| cfg_wdata | input | DATA_W | Write data |
| coef_rd_phase | input | 5 | Phase to read from the coefficient store |
| coef_rd_data | output | WPP*COEF_W | Coefficient words of the requested phase |
| pix_valid | output | 1 | An output pixel is presented this cycle |
| line_done | output | 1 | Last pixel of the line |
| luma_idx | output | IN_W | Luma source index |
| luma_phase | output | 5 | Luma filter phase |
| chroma_idx | output | IN_W | Chroma source index |
| chroma_phase | output | 5 | Chroma filter phase |

## Verification
The assertions assume software programs a nonzero output size before it commits. They also assume it sends no second request while a step is computing, except where ignoring that request is itself under test. Every commit in the stimulus is followed by a wait longer than the divider latency before a line start. The bench also keeps the control hold bit constant across line starts, so coefficient traffic and scanning never overlap in a way the scoreboard must model.

// File: rtl/scl_step_pkg.sv
package scl_step_pkg;

    localparam int FRAC_W  = 16;
    localparam int PH_BITS = 5;
    localparam int PHASES  = 1 << PH_BITS;
    localparam int INIT_W  = 20;

    localparam int REG_LIN    = 0;
    localparam int REG_OUT    = 1;
    localparam int REG_MODE   = 2;
    localparam int REG_INIT_L = 3;
    localparam int REG_INIT_C = 4;
    localparam int REG_CTRL   = 5;
    localparam int COEF_BASE  = 'h40;

    localparam int CTRL_COMMIT = 0;
    localparam int CTRL_START  = 1;
    localparam int CTRL_HOLD   = 2;
    localparam int MODE_MP_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIV,
        ST_SCAN
    } seq_state_e;

    typedef struct packed {
        logic       multi;
        logic [1:0] shift;
    } mode_t;

    function automatic logic [31:0] ceil_shr(input logic [31:0] v, input logic [1:0] sh);
        return (v + ((32'd1 << sh) - 32'd1)) >> sh;
    endfunction

endpackage

// File: rtl/scl_step_div.sv
module scl_step_div #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             busy,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] dvd;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W:0]   trial;
    logic             fits;

    always_comb begin
        trial = {rem, dvd[NUM_W-1]};
        fits  = trial >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd   <= '0;
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            quo   <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            dvd   <= num;
            den_q <= den;
            rem   <= '0;
            quo   <= '0;
            cnt   <= CNT_W'(NUM_W);
            busy  <= 1'b1;
        end else if (busy) begin
            if (fits) begin
                rem <= DEN_W'(trial - {1'b0, den_q});
                quo <= {quo[NUM_W-2:0], 1'b1};
            end else begin
                rem <= trial[DEN_W-1:0];
                quo <= {quo[NUM_W-2:0], 1'b0};
            end
            dvd <= dvd << 1;
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // R2: the iteration runs to the end once started
    a_r2_div_runs: assert property (@(posedge clk) disable iff (rst)
        busy && cnt != CNT_W'(1) |=> busy);

    // R2: a finished quotient stays put until the next start
    a_r2_quo_held: assert property (@(posedge clk) disable iff (rst)
        !busy && !start |=> $stable(quo));

endmodule

// File: rtl/scl_step_accum.sv
module scl_step_accum
    import scl_step_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int STEP_W = 28,
    parameter int ACC_W  = 30
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               adv,
    input  logic [INIT_W-1:0]  init,
    input  logic [STEP_W-1:0]  step,
    input  logic [IN_W-1:0]    in_size,
    output logic [IN_W-1:0]    idx,
    output logic [PH_BITS-1:0] phase
);
    localparam int INT_W = ACC_W - FRAC_W;

    logic signed [ACC_W-1:0] acc;
    logic [INT_W-1:0]        int_part;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (load) begin
            acc <= {{(ACC_W-INIT_W){init[INIT_W-1]}}, init};
        end else if (adv) begin
            acc <= acc + $signed({{(ACC_W-STEP_W){1'b0}}, step});
        end
    end

    always_comb begin
        int_part = acc[ACC_W-1:FRAC_W];
        if (int_part[INT_W-1]) begin
            idx = '0;
        end else if (in_size == '0) begin
            idx = '0;
        end else if (int_part >= {{(INT_W-IN_W){1'b0}}, in_size}) begin
            idx = in_size - 1'b1;
        end else begin
            idx = int_part[IN_W-1:0];
        end
        phase = acc[FRAC_W-1 -: PH_BITS];
    end

    // R5: a line start brings the initial phase straight to the output
    a_r5_phase_restart: assert property (@(posedge clk) disable iff (rst)
        load |=> phase == $past(init[FRAC_W-1 -: PH_BITS]));

endmodule

// File: rtl/scl_coef_store.sv
module scl_coef_store
    import scl_step_pkg::*;
#(
    parameter int COEF_W = 32,
    parameter int WPP    = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hold,
    input  logic                    we,
    input  logic [$clog2(PHASES*WPP)-1:0] widx,
    input  logic [COEF_W-1:0]       wdata,
    input  logic [PH_BITS-1:0]      rd_phase,
    output logic [WPP*COEF_W-1:0]   rd_data
);
    localparam int DEPTH  = PHASES * WPP;
    localparam int CIDX_W = $clog2(DEPTH);

    logic [DEPTH-1:0][COEF_W-1:0] staged;
    logic [DEPTH-1:0][COEF_W-1:0] active;
    logic                         hold_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= '0;
        end else if (we && hold) begin
            staged[widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
            hold_d <= 1'b0;
        end else begin
            hold_d <= hold;
            if (hold_d && !hold) active <= staged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            for (int w = 0; w < WPP; w++) begin
                rd_data[w*COEF_W +: COEF_W] <= active[CIDX_W'(int'(rd_phase) * WPP + w)];
            end
        end
    end

    // R9: the set seen by the filter cannot change while software holds access
    a_r9_active_held: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(active));

    // R8: without the hold bit nothing lands in the staging copy
    a_r8_staged_locked: assert property (@(posedge clk) disable iff (rst)
        !hold |=> $stable(staged));

endmodule

// File: rtl/scl_phase_stepper.sv
module scl_phase_stepper
    import scl_step_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 12,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int COEF_W = 32,
    parameter int WPP    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [DATA_W-1:0]     cfg_wdata,
    input  logic [PH_BITS-1:0]    coef_rd_phase,
    output logic [WPP*COEF_W-1:0] coef_rd_data,
    output logic                  pix_valid,
    output logic                  line_done,
    output logic [IN_W-1:0]       luma_idx,
    output logic [PH_BITS-1:0]    luma_phase,
    output logic [IN_W-1:0]       chroma_idx,
    output logic [PH_BITS-1:0]    chroma_phase
);
    localparam int STEP_W = IN_W + FRAC_W;
    localparam int ACC_W  = IN_W + FRAC_W + 2;
    localparam int DEPTH  = PHASES * WPP;
    localparam int CIDX_W = $clog2(DEPTH);
    localparam int NCH    = 2;

    logic [IN_W-1:0]   sh_lin, act_lin, act_cin, cin_next;
    logic [OUT_W-1:0]  sh_out, act_out, pix_cnt;
    mode_t             sh_mode, act_mode;
    logic [INIT_W-1:0] sh_init_l, sh_init_c, act_init_l, act_init_c;
    logic              hold_q;
    seq_state_e        state;

    logic is_ctrl, commit_req, start_req, commit_ok, start_ok, scanning, last_pix, divs_idle;
    logic coef_we;
    logic [CIDX_W-1:0] coef_widx;

    logic [STEP_W-1:0]  div_num [NCH];
    logic [STEP_W-1:0]  ch_step [NCH];
    logic [NCH-1:0]     div_busy;
    logic [INIT_W-1:0]  ch_init [NCH];
    logic [IN_W-1:0]    ch_size [NCH];
    logic [IN_W-1:0]    ch_idx  [NCH];
    logic [PH_BITS-1:0] ch_phase[NCH];

    always_comb begin
        is_ctrl    = cfg_we && cfg_addr == ADDR_W'(REG_CTRL);
        commit_req = is_ctrl && cfg_wdata[CTRL_COMMIT];
        start_req  = is_ctrl && cfg_wdata[CTRL_START] && !cfg_wdata[CTRL_COMMIT];
        commit_ok  = commit_req && state == ST_IDLE;
        start_ok   = start_req && state == ST_IDLE && act_out != '0;
        scanning   = state == ST_SCAN;
        last_pix   = pix_cnt == act_out - 1'b1;
        divs_idle  = div_busy == '0;
        cin_next   = IN_W'(ceil_shr(32'(sh_lin), sh_mode.shift));
        coef_we    = cfg_we && int'(cfg_addr) >= COEF_BASE && int'(cfg_addr) < COEF_BASE + DEPTH;
        coef_widx  = CIDX_W'(int'(cfg_addr) - COEF_BASE);

        div_num[0] = {sh_lin, {FRAC_W{1'b0}}};
        div_num[1] = {cin_next, {FRAC_W{1'b0}}};
        ch_init[0] = act_init_l;
        ch_init[1] = act_mode.multi ? act_init_c : act_init_l;
        ch_size[0] = act_lin;
        ch_size[1] = act_cin;
    end

    // staging registers, control hold bit
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_lin    <= '0;
            sh_out    <= '0;
            sh_mode   <= '0;
            sh_init_l <= '0;
            sh_init_c <= '0;
            hold_q    <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_addr == ADDR_W'(REG_LIN))    sh_lin    <= cfg_wdata[IN_W-1:0];
            if (cfg_addr == ADDR_W'(REG_OUT))    sh_out    <= cfg_wdata[OUT_W-1:0];
            if (cfg_addr == ADDR_W'(REG_MODE))   sh_mode   <= '{multi: cfg_wdata[MODE_MP_BIT], shift: cfg_wdata[1:0]};
            if (cfg_addr == ADDR_W'(REG_INIT_L)) sh_init_l <= cfg_wdata[INIT_W-1:0];
            if (cfg_addr == ADDR_W'(REG_INIT_C)) sh_init_c <= cfg_wdata[INIT_W-1:0];
            if (is_ctrl)                         hold_q    <= cfg_wdata[CTRL_HOLD];
        end
    end

    // sequencer and active set
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            pix_cnt    <= '0;
            act_lin    <= '0;
            act_cin    <= '0;
            act_out    <= '0;
            act_mode   <= '0;
            act_init_l <= '0;
            act_init_c <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (commit_ok) begin
                        act_lin    <= sh_lin;
                        act_cin    <= cin_next;
                        act_out    <= sh_out;
                        act_mode   <= sh_mode;
                        act_init_l <= sh_init_l;
                        act_init_c <= sh_init_c;
                        state      <= ST_DIV;
                    end else if (start_ok) begin
                        pix_cnt <= '0;
                        state   <= ST_SCAN;
                    end
                end
                ST_DIV: begin
                    if (divs_idle) state <= ST_IDLE;
                end
                ST_SCAN: begin
                    if (last_pix) state   <= ST_IDLE;
                    else          pix_cnt <= pix_cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        scl_step_div #(
            .NUM_W (STEP_W),
            .DEN_W (OUT_W)
        ) u_div (
            .clk   (clk),
            .rst   (rst),
            .start (commit_ok),
            .num   (div_num[ch]),
            .den   (sh_out),
            .busy  (div_busy[ch]),
            .quo   (ch_step[ch])
        );

        scl_step_accum #(
            .IN_W   (IN_W),
            .STEP_W (STEP_W),
            .ACC_W  (ACC_W)
        ) u_acc (
            .clk     (clk),
            .rst     (rst),
            .load    (start_ok),
            .adv     (scanning),
            .init    (ch_init[ch]),
            .step    (ch_step[ch]),
            .in_size (ch_size[ch]),
            .idx     (ch_idx[ch]),
            .phase   (ch_phase[ch])
        );
    end

    scl_coef_store #(
        .COEF_W (COEF_W),
        .WPP    (WPP)
    ) u_coef (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold_q),
        .we       (coef_we),
        .widx     (coef_widx),
        .wdata    (cfg_wdata[COEF_W-1:0]),
        .rd_phase (coef_rd_phase),
        .rd_data  (coef_rd_data)
    );

    assign pix_valid    = scanning;
    assign line_done    = scanning && last_pix;
    assign luma_idx     = ch_idx[0];
    assign luma_phase   = ch_phase[0];
    assign chroma_idx   = ch_idx[1];
    assign chroma_phase = ch_phase[1];

    // R4: the last pixel closes the line
    a_r4_done_ends_line: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !pix_valid);

    // R4: a line has no gaps before its last pixel
    a_r4_line_contiguous: assert property (@(posedge clk) disable iff (rst)
        pix_valid && !line_done |=> pix_valid);

    // R1: active sizes move only on a commit request
    a_r1_shadow_only: assert property (@(posedge clk) disable iff (rst)
        !(is_ctrl && cfg_wdata[CTRL_COMMIT]) |=> $stable(act_lin) && $stable(act_out));

    // R7: the luma index never leaves the input
    a_r7_idx_bound: assert property (@(posedge clk) disable iff (rst)
        pix_valid && act_lin != '0 |-> luma_idx < act_lin);

endmodule

// File: tb/scl_phase_stepper_tb.sv
`timescale 1ns/1ps
module scl_phase_stepper_tb;

    localparam int IN_W   = 12;
    localparam int OUT_W  = 12;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int COEF_W = 32;
    localparam int WPP    = 2;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cfg_we = 1'b0;
    logic [ADDR_W-1:0]     cfg_addr = '0;
    logic [DATA_W-1:0]     cfg_wdata = '0;
    logic [4:0]            coef_rd_phase = '0;
    logic [WPP*COEF_W-1:0] coef_rd_data;
    logic                  pix_valid, line_done;
    logic [IN_W-1:0]       luma_idx, chroma_idx;
    logic [4:0]            luma_phase, chroma_phase;

    scl_phase_stepper #(
        .IN_W(IN_W), .OUT_W(OUT_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .COEF_W(COEF_W), .WPP(WPP)
    ) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .coef_rd_phase(coef_rd_phase),
        .coef_rd_data(coef_rd_data), .pix_valid(pix_valid),
        .line_done(line_done), .luma_idx(luma_idx), .luma_phase(luma_phase),
        .chroma_idx(chroma_idx), .chroma_phase(chroma_phase)
    );

    always #4 clk = ~clk;

    typedef struct {
        string  tag;
        longint lidx, lph, cidx, cph;
        bit     done;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a pixel is presented
    always @(negedge clk) begin
        if (!rst && pix_valid) begin
            if (q.size() == 0) begin
                check("R4", "unexpected pixel", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "luma_idx",     longint'(luma_idx),     e.lidx);
                check(e.tag, "luma_phase",   longint'(luma_phase),   e.lph);
                check(e.tag, "chroma_idx",   longint'(chroma_idx),   e.cidx);
                check(e.tag, "chroma_phase", longint'(chroma_phase), e.cph);
                check("R4",  "line_done",    longint'(line_done),    longint'(e.done));
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic cfg_write(input int addr, input longint data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = ADDR_W'(addr);
        cfg_wdata = DATA_W'(data);
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic longint sx20(input longint v);
        longint m;
        m = v & 'hFFFFF;
        return (m >= 'h80000) ? m - 'h100000 : m;
    endfunction

    function automatic longint clampi(input longint a, input longint sz);
        longint ip;
        ip = a >>> 16;
        if (ip < 0 || sz == 0) return 0;
        if (ip >= sz) return sz - 1;
        return ip;
    endfunction

    // scoreboard driver: computes one line from the requirements
    task automatic push_line(input string tag, input int lin, input int outsz, input int sh,
                             input longint il, input longint ic, input bit mp);
        longint cin, ls, cs, li, ci;
        cin = (lin + (1 << sh) - 1) >> sh;
        ls  = (longint'(lin) << 16) / outsz;
        cs  = (cin << 16) / outsz;
        li  = sx20(il);
        ci  = mp ? sx20(ic) : sx20(il);
        for (int i = 0; i < outsz; i++) begin
            exp_t e;
            longint la, ca;
            la = li + longint'(i) * ls;
            ca = ci + longint'(i) * cs;
            e.tag  = tag;
            e.lidx = clampi(la, lin);
            e.lph  = (la >> 11) & 31;
            e.cidx = clampi(ca, cin);
            e.cph  = (ca >> 11) & 31;
            e.done = (i == outsz - 1);
            q.push_back(e);
        end
    endtask

    task automatic configure(input int lin, input int outsz, input int sh,
                             input longint il, input longint ic, input bit mp);
        cfg_write(0, lin);
        cfg_write(1, outsz);
        cfg_write(2, (mp ? 16 : 0) | sh);
        cfg_write(3, il);
        cfg_write(4, ic);
        cfg_write(5, 1);
        repeat (40) @(negedge clk);
    endtask

    task automatic drain(input string tag, input int outsz);
        repeat (outsz + 6) @(negedge clk);
        check(tag, "scoreboard left", q.size(), 0);
    endtask

    task automatic run_line(input string tag, input int lin, input int outsz, input int sh,
                            input longint il, input longint ic, input bit mp);
        push_line(tag, lin, outsz, sh, il, ic, mp);
        cfg_write(5, 2);
        drain(tag, outsz);
    endtask

    task automatic read_coef(input string tag, input int p, input longint e0, input longint e1);
        @(negedge clk);
        coef_rd_phase = 5'(p);
        @(negedge clk);
        check(tag, "coef word0", longint'(coef_rd_data[COEF_W-1:0]), e0);
        check(tag, "coef word1", longint'(coef_rd_data[2*COEF_W-1:COEF_W]), e1);
    endtask

    function automatic longint cval(input int p, input int w);
        return 'h10000000 + p * 256 + w;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        check("R11", "pix_valid after reset", longint'(pix_valid), 0);
        read_coef("R11", 9, 0, 0);
        cfg_write(5, 2);            // R11: start with zero active size is ignored
        repeat (8) @(negedge clk);

        // R2 R3 R5: downscale by two, chroma half width
        configure(64, 32, 1, 0, 0, 0);
        run_line("R2 R3 R5", 64, 32, 1, 0, 0, 0);

        // R2 R3: upscale with fractional step
        configure(10, 33, 1, 0, 0, 0);
        run_line("R2 R3", 10, 33, 1, 0, 0, 0);

        // R3: odd ceiling division with shift 2
        configure(13, 7, 2, 0, 0, 0);
        run_line("R3", 13, 7, 2, 0, 0, 0);

        // R6 R7: multi-plane chroma starts a quarter pixel early and clamps at zero
        configure(40, 17, 1, 'h00400, 'hFC000, 1);
        run_line("R6 R7", 40, 17, 1, 'h00400, 'hFC000, 1);

        // R6: single-plane source ignores the chroma initial phase
        configure(40, 17, 1, 'h00400, 'hFC000, 0);
        run_line("R6", 40, 17, 1, 'h00400, 'hFC000, 0);

        // R7: a large initial phase pushes the index against the top
        configure(8, 8, 0, 'h30000, 'h30000, 1);
        run_line("R7", 8, 8, 0, 'h30000, 'h30000, 1);

        // R5: a second line restarts from the initial phase
        run_line("R5", 8, 8, 0, 'h30000, 'h30000, 1);

        // R1: staged values without a commit leave the active line unchanged
        configure(20, 10, 0, 0, 0, 0);
        cfg_write(0, 50);
        cfg_write(1, 5);
        run_line("R1", 20, 10, 0, 0, 0, 0);
        cfg_write(5, 1);
        repeat (40) @(negedge clk);
        run_line("R1", 50, 5, 0, 0, 0, 0);

        // R4: a start during a scan is ignored
        push_line("R4", 50, 5, 0, 0, 0, 0);
        cfg_write(5, 2);
        cfg_write(5, 2);
        drain("R4", 5);

        // R4: a start while the steps compute is ignored
        cfg_write(0, 30);
        cfg_write(1, 12);
        cfg_write(5, 1);
        cfg_write(5, 2);
        repeat (40) @(negedge clk);
        check("R4", "scoreboard during divide", q.size(), 0);
        run_line("R2 R4", 30, 12, 0, 0, 0, 0);

        // R8: coefficient write without hold is dropped
        cfg_write('h40 + 5 * WPP, 'hAAAA0005);
        cfg_write(5, 4);
        cfg_write(5, 0);
        repeat (2) @(negedge clk);
        read_coef("R8", 5, 0, 0);

        // R9 R10: load all phases under hold
        cfg_write(5, 4);
        for (int p = 0; p < 32; p++) begin
            for (int w = 0; w < WPP; w++) begin
                cfg_write('h40 + p * WPP + w, cval(p, w));
            end
        end
        read_coef("R9", 5, 0, 0);
        cfg_write(5, 0);
        repeat (2) @(negedge clk);
        read_coef("R10", 0, cval(0, 0), cval(0, 1));
        read_coef("R10", 5, cval(5, 0), cval(5, 1));
        read_coef("R10", 31, cval(31, 0), cval(31, 1));

        // R8: a write after release does not reach the set
        cfg_write('h40 + 3 * WPP, 'hDEAD0003);
        cfg_write(5, 4);
        cfg_write(5, 0);
        repeat (2) @(negedge clk);
        read_coef("R8", 3, cval(3, 0), cval(3, 1));

        // R9: single update is hidden during hold, visible after release
        cfg_write(5, 4);
        cfg_write('h40 + 7 * WPP + 1, 'h55667788);
        read_coef("R9", 7, cval(7, 0), cval(7, 1));
        cfg_write(5, 0);
        repeat (2) @(negedge clk);
        read_coef("R9", 7, cval(7, 0), 'h55667788);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule